// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Datapath

This block is the datapath half of a processor that runs each instruction over several clock cycles. A single arithmetic unit is reused in different cycles for the program-counter increment, the branch target, the effective address and register arithmetic. A single word-addressed memory holds both instructions and data. An address multiplexer picks whether a cycle fetches at the program counter or accesses data at the latched arithmetic result. Intermediate registers carry values from one cycle to the next: the held instruction, two operand latches, the latched arithmetic result and the latched memory word.

The block has no sequencer. Every steering and write-enable signal is a port, and an external controller (here the testbench) drives them cycle by cycle. The outputs are the zero flag, the held instruction word and the program counter. Memory contents are loaded from the `MEM_INIT` parameter whenever reset is asserted, so the program is given at elaboration.

The house style's state machine does not apply, since sequencing lives outside the block. Its naming, synchronous reset and process layout are kept. The typical cycle sequences are:
- fetch, then decode, then execute, then write-back for register arithmetic;
- fetch, decode, address, memory read, write-back for loads;
- fetch, decode, address, memory write for stores;
- fetch, decode, compare for branches.

Top module: `mc_datapath`

## Requirements
- R1: Synchronous active-high reset clears the program counter, held instruction, intermediate registers and all general registers to 0, and reloads every memory word from `MEM_INIT`.
- R2: The program counter changes only on an edge where `pc_wr` is 1, and the held instruction changes only on an edge where `ir_wr` is 1. With `addr_sel`=0 the memory is read at the program counter. With `pc_sel`=0 the program counter loads the live arithmetic result.
- R3: With `opa_sel`=0 the first arithmetic operand is the program counter; with `opa_sel`=1 it is operand latch A.
- R4: `opb_sel` picks the second operand: 0 operand latch B, 1 the constant 4, 2 the sign-extended instruction bits [15:0], 3 that value shifted left by 2.
- R5: `alu_op` codes are 010 add, 110 subtract, 000 bitwise and, 001 bitwise or, 111 signed set-less-than (result 1 or 0). `zero` is 1 exactly when the live result is 0.
- R6: Operand latches A and B, the latched result and the latched memory word capture new values on every clock edge, with no enable.
- R7: Register reads use instruction bits [25:21] (to A) and [20:16] (to B). When `rf_wr` is 1 the write register is bits [20:16] if `dst_sel`=0 or bits [15:11] if `dst_sel`=1. The write data is the latched result if `wb_sel`=0 or the latched memory word if `wb_sel`=1.
- R8: General register 0 always reads 0, and writes to it are ignored.
- R9: With `addr_sel`=1 the memory index is the latched result. Address bits [1:0] are ignored. Read data is combinational and is forced to 0 when `mem_rd` is 0. When `mem_wr` is 1, operand latch B is written to the addressed word at the clock edge.
- R10: With `pc_sel`=1 and `pc_wr`=1, the program counter loads the latched result (the branch target).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_wr | input | 1 | Program counter load enable |
| ir_wr | input | 1 | Held-instruction load enable |
| addr_sel | input | 1 | Memory address source: 0 program counter, 1 latched result |
| mem_rd | input | 1 | Memory read enable (read data is 0 when low) |
| mem_wr | input | 1 | Memory write enable |
| dst_sel | input | 1 | Write register field: 0 bits [20:16], 1 bits [15:11] |
| wb_sel | input | 1 | Write-back source: 0 latched result, 1 latched memory word |
| rf_wr | input | 1 | General register write enable |
| opa_sel | input | 1 | First operand: 0 program counter, 1 latch A |
| opb_sel | input | 2 | Second operand: B, 4, immediate, shifted immediate |
| pc_sel | input | 1 | Next program counter: 0 live result, 1 latched result |
| alu_op | input | 3 | Arithmetic operation code |
| zero | output | 1 | Live arithmetic result equals 0 |
| instr | output | 32 | Held instruction word |
| pc | output | 32 | Program counter |

## Verification
Several properties are checked on every cycle:
- the program counter and held instruction keep their values when their enables are low;
- the latched result always follows the previous cycle's live result;
- both program-counter load paths take the right source;
- a subtract of equal operands raises `zero`;
- register 0 reads as 0;
- a memory word written at an address reads back on the next cycle.

Some behaviour only the bench's instruction sequences can show:
- the decode of register fields;
- the write-back source choice;
- the sign extension of negative offsets;
- signed rather than unsigned comparison;
- the ignored write to register 0;
- branch taken versus not taken;
- the reload of memory on reset.

The bench shows these by storing results to memory and fetching them back into the held instruction.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG   = 2'd0,
        OPB_FOUR  = 2'd1,
        OPB_IMM   = 2'd2,
        OPB_IMMSH = 2'd3
    } opb_sel_e;

    localparam int IMM_W    = 16;
    localparam int RS_MSB   = 25;
    localparam int RT_MSB   = 20;
    localparam int RD_MSB   = 15;

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [2:0]   op,
    output logic [W-1:0] res,
    output logic         zero
);

    always_comb begin
        unique case (alu_op_e'(op))
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
    parameter int W    = 32,
    parameter int REGS = 32,
    localparam int AW  = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_data_a,
    output logic [W-1:0]  rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] regs_q [REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
        end else if (wr_en && (wr_addr != '0)) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data_a = (rd_addr_a == '0) ? '0 : regs_q[rd_addr_a];
        rd_data_b = (rd_addr_b == '0) ? '0 : regs_q[rd_addr_b];
    end

    // R8
    r0_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

endmodule

// File: rtl/mcd_mem.sv
module mcd_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter logic [W-1:0] INIT [DEPTH] = '{default: '0},
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] idx,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= INIT[i];
        end else if (wr_en) begin
            words_q[idx] <= wr_data;
        end
    end

    assign rd_data = rd_en ? words_q[idx] : '0;

    // R9
    write_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> ((idx != $past(idx)) || !rd_en || (rd_data == $past(wr_data))));

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mcd_pkg::*;
#(
    parameter int W         = 32,
    parameter int REGS      = 32,
    parameter int MEM_WORDS = 32,
    parameter logic [W-1:0] MEM_INIT [MEM_WORDS] = '{default: '0}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pc_wr,
    input  logic         ir_wr,
    input  logic         addr_sel,
    input  logic         mem_rd,
    input  logic         mem_wr,
    input  logic         dst_sel,
    input  logic         wb_sel,
    input  logic         rf_wr,
    input  logic         opa_sel,
    input  logic [1:0]   opb_sel,
    input  logic         pc_sel,
    input  logic [2:0]   alu_op,
    output logic         zero,
    output logic [W-1:0] instr,
    output logic [W-1:0] pc
);

    localparam int REG_AW = $clog2(REGS);
    localparam int MEM_AW = $clog2(MEM_WORDS);

    logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
    logic [W-1:0] mem_rdata, rf_a, rf_b, opa_val, opb_val, alu_res, wb_data;
    logic [W-1:0] imm_ext;
    logic [MEM_AW-1:0] mem_idx;
    logic [REG_AW-1:0] wr_reg;

    // address multiplexer: fetch at PC, data at latched result
    assign mem_idx = addr_sel ? alu_out_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

    mcd_mem #(.W(W), .DEPTH(MEM_WORDS), .INIT(MEM_INIT)) mem_i (
        .clk(clk), .rst(rst), .idx(mem_idx), .rd_en(mem_rd),
        .wr_en(mem_wr), .wr_data(b_q), .rd_data(mem_rdata)
    );

    assign wr_reg  = dst_sel ? ir_q[RD_MSB -: REG_AW] : ir_q[RT_MSB -: REG_AW];
    assign wb_data = wb_sel ? mdr_q : alu_out_q;

    mcd_regfile #(.W(W), .REGS(REGS)) rf_i (
        .clk(clk), .rst(rst),
        .rd_addr_a(ir_q[RS_MSB -: REG_AW]), .rd_addr_b(ir_q[RT_MSB -: REG_AW]),
        .rd_data_a(rf_a), .rd_data_b(rf_b),
        .wr_en(rf_wr), .wr_addr(wr_reg), .wr_data(wb_data)
    );

    assign imm_ext = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign opa_val = opa_sel ? a_q : pc_q;

    always_comb begin
        unique case (opb_sel_e'(opb_sel))
            OPB_REG:   opb_val = b_q;
            OPB_FOUR:  opb_val = W'(4);
            OPB_IMM:   opb_val = imm_ext;
            OPB_IMMSH: opb_val = {imm_ext[W-3:0], 2'b00};
            default:   opb_val = '0;
        endcase
    end

    mcd_alu #(.W(W)) alu_i (
        .opa(opa_val), .opb(opb_val), .op(alu_op), .res(alu_res), .zero(zero)
    );

    // state registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            ir_q      <= '0;
            mdr_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            alu_out_q <= '0;
        end else begin
            if (pc_wr) pc_q <= pc_sel ? alu_out_q : alu_res;
            if (ir_wr) ir_q <= mem_rdata;
            mdr_q     <= mem_rdata;
            a_q       <= rf_a;
            b_q       <= rf_b;
            alu_out_q <= alu_res;
        end
    end

    // outputs
    always_comb begin
        pc    = pc_q;
        instr = ir_q;
    end

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pc_wr |=> $stable(pc_q));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    // R2
    pc_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && !pc_sel) |=> (pc_q == $past(alu_res)));

    // R10
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_sel) |=> (pc_q == $past(alu_out_q)));

    // R6
    alu_out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (alu_out_q == $past(alu_res)));

    // R5
    sub_equal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((alu_op == 3'b110) && (opa_val == opb_val)) |-> zero);

endmodule

// File: tb/mc_datapath_tb_top.sv
module mc_datapath_tb_top;

    localparam int NSTEPS = 20;
    localparam logic [1:0] K_LW = 2'd0, K_SW = 2'd1, K_R = 2'd2, K_BEQ = 2'd3;
    localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                           OP_SUB = 3'b110, OP_SLT = 3'b111;

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, rt, input int imm);
        return {opc, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    localparam logic [31:0] PROG [32] = '{
        enc_i(6'h23, 0, 9, 112),          // 0  lw  r9 <- word28 (7)
        enc_i(6'h23, 0, 10, 116),         // 1  lw  r10 <- word29 (5)
        enc_r(9, 10, 11, 6'h20),          // 2  add r11 = 12
        enc_i(6'h2b, 0, 11, 124),         // 3  sw  r11
        enc_r(10, 9, 12, 6'h22),          // 4  sub r12 = -2
        enc_i(6'h2b, 0, 12, 124),         // 5  sw  r12
        enc_r(9, 10, 13, 6'h24),          // 6  and r13 = 5
        enc_i(6'h2b, 0, 13, 124),         // 7  sw  r13
        enc_r(9, 10, 14, 6'h25),          // 8  or  r14 = 7
        enc_i(6'h2b, 0, 14, 124),         // 9  sw  r14
        enc_r(10, 9, 15, 6'h2a),          // 10 slt r15 = 1
        enc_i(6'h2b, 0, 15, 124),         // 11 sw  r15
        enc_r(9, 12, 16, 6'h2a),          // 12 slt r16 = 0 (signed)
        enc_r(9, 10, 0, 6'h20),           // 13 add r0 (ignored)
        enc_i(6'h2b, 0, 0, 124),          // 14 sw  r0
        enc_i(6'h04, 9, 10, 5),           // 15 beq not taken
        enc_i(6'h04, 9, 9, 2),            // 16 beq taken -> word 19
        32'hDEAD_0001, 32'hDEAD_0002,     // 17,18 skipped
        enc_i(6'h2b, 0, 10, 112),         // 19 sw  r10 -> word28
        enc_i(6'h23, 11, 18, -4),         // 20 lw  r18 <- 12-4 = word2
        enc_i(6'h2b, 0, 18, 124),         // 21 sw  r18
        32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0,
        32'd7, 32'd5, 32'd0, 32'd0        // 28..31 data
    };

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  op;
        logic        z;
        logic [31:0] exp;
    } step_t;

    // vector table: kind, alu op, expected zero, expected value (store readback or next PC)
    localparam step_t STEPS [NSTEPS] = '{
        '{K_LW,  OP_ADD, 1'b0, 32'd0},
        '{K_LW,  OP_ADD, 1'b0, 32'd0},
        '{K_R,   OP_ADD, 1'b0, 32'd12},
        '{K_SW,  OP_ADD, 1'b0, 32'd12},
        '{K_R,   OP_SUB, 1'b0, 32'hFFFF_FFFE},
        '{K_SW,  OP_ADD, 1'b0, 32'hFFFF_FFFE},
        '{K_R,   OP_AND, 1'b0, 32'd5},
        '{K_SW,  OP_ADD, 1'b0, 32'd5},
        '{K_R,   OP_OR,  1'b0, 32'd7},
        '{K_SW,  OP_ADD, 1'b0, 32'd7},
        '{K_R,   OP_SLT, 1'b0, 32'd1},
        '{K_SW,  OP_ADD, 1'b0, 32'd1},
        '{K_R,   OP_SLT, 1'b1, 32'd0},
        '{K_R,   OP_ADD, 1'b0, 32'd12},
        '{K_SW,  OP_ADD, 1'b0, 32'd0},
        '{K_BEQ, OP_SUB, 1'b0, 32'd64},
        '{K_BEQ, OP_SUB, 1'b1, 32'd76},
        '{K_SW,  OP_ADD, 1'b0, 32'd5},
        '{K_LW,  OP_ADD, 1'b0, 32'd0},
        '{K_SW,  OP_ADD, 1'b0, enc_r(9, 10, 11, 6'h20)}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_wr, ir_wr, addr_sel, mem_rd, mem_wr, dst_sel, wb_sel, rf_wr, opa_sel, pc_sel;
    logic [1:0] opb_sel;
    logic [2:0] alu_op;
    logic zero;
    logic [31:0] instr, pc;

    int checks = 0;
    int fails  = 0;
    logic [31:0] epc = 32'd0;

    always #2 clk = ~clk;

    mc_datapath #(.MEM_INIT(PROG)) dut_i (
        .clk(clk), .rst(rst), .pc_wr(pc_wr), .ir_wr(ir_wr), .addr_sel(addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .rf_wr(rf_wr), .opa_sel(opa_sel), .opb_sel(opb_sel), .pc_sel(pc_sel),
        .alu_op(alu_op), .zero(zero), .instr(instr), .pc(pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctl(input logic pcw, irw, asel, mrd, mwr, dst, wb, rfw, oa,
                       input logic [1:0] ob, input logic ps, input logic [2:0] op);
        pc_wr = pcw; ir_wr = irw; addr_sel = asel; mem_rd = mrd; mem_wr = mwr;
        dst_sel = dst; wb_sel = wb; rf_wr = rfw; opa_sel = oa; opb_sel = ob;
        pc_sel = ps; alu_op = op;
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_fetch;
        ctl(1, 1, 0, 1, 0, 0, 0, 0, 0, 2'd1, 0, OP_ADD);
        tick;
        chk("R2 fetch instr", instr, PROG[epc[6:2]]);
        epc = epc + 32'd4;
        chk("R2 pc+4", pc, epc);
    endtask

    task automatic do_decode;
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 0, OP_ADD);
        tick;
        chk("R2 pc hold", pc, epc);
    endtask

    task automatic do_r(input logic [2:0] op, input logic z);
        logic [31:0] held;
        held = instr;
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0, op);
        #1 chk("R5 zero", 32'(zero), 32'(z));
        tick;
        ctl(0, 0, 0, 0, 0, 1, 0, 1, 1, 2'd0, 0, op);
        tick;
        chk("R2 ir hold", instr, held);
    endtask

    task automatic do_lw;
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        ctl(0, 0, 1, 1, 0, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        ctl(0, 0, 0, 0, 0, 0, 1, 1, 1, 2'd2, 0, OP_ADD);
        tick;
    endtask

    task automatic do_sw(input logic [31:0] exp);
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        ctl(0, 0, 1, 0, 1, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        ctl(0, 1, 1, 1, 0, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        chk("R9 R7 R8 store readback", instr, exp);
    endtask

    task automatic do_beq(input logic [31:0] exp_pc, input logic z);
        ctl(z, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 1, OP_SUB);
        #1 chk("R10 compare zero", 32'(zero), 32'(z));
        tick;
        epc = exp_pc;
        chk("R10 branch pc", pc, exp_pc);
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        report;
    end

    initial begin
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, OP_AND);
        rst = 1'b1;
        tick;
        tick;
        // R1 reset state
        chk("R1 reset pc", pc, 32'd0);
        chk("R1 reset instr", instr, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NSTEPS; i++) begin
            do_fetch;
            do_decode;
            unique case (STEPS[i].kind)
                K_LW:  do_lw;
                K_SW:  do_sw(STEPS[i].exp);
                K_R:   do_r(STEPS[i].op, STEPS[i].z);
                K_BEQ: do_beq(STEPS[i].exp, STEPS[i].z);
                default: ;
            endcase
        end

        // R1: mid-run reset returns pc/instr to 0 and reloads word 28 (overwritten with 5)
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 0, OP_AND);
        rst = 1'b1;
        tick;
        rst = 1'b0;
        chk("R1 reset pc again", pc, 32'd0);
        chk("R1 reset instr again", instr, 32'd0);
        epc = 32'd0;
        do_fetch;
        do_decode;
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        ctl(0, 1, 1, 1, 0, 0, 0, 0, 1, 2'd2, 0, OP_ADD);
        tick;
        chk("R1 memory reloaded", instr, 32'd7);

        // R9: read data is 0 when mem_rd is low (pc=4 holds a nonzero word)
        ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd1, 0, OP_ADD);
        tick;
        chk("R9 gated read", instr, 32'd0);

        // R3/R4: PC + const 4 observed through zero (pc=4: 4+4 != 0; 4-4 == 0)
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 0, OP_SUB);
        #1 chk("R3 R4 pc minus four", 32'(zero), 32'd1);
        ctl(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 0, OP_ADD);
        #1 chk("R3 R4 pc plus four", 32'(zero), 32'd0);

        report;
    end

endmodule